// File: doc/BRIEF.md
# Convolutional Byte Encoder with Nucleotide Letter Output

This block takes one 8-bit message byte at a time and runs it through a rate-1/2 convolutional encoder with constraint length 3, which has four states. The encoder handles one message bit per clock, starting with the most significant bit. Before each byte, both state flip-flops are set to zero. For every message bit the encoder produces two coded bits, so one byte gives a 16-bit codeword. No tail bits are added at the end.

Once the codeword is complete, the block shows it on a parallel output. It also streams the codeword as eight ASCII characters, one for each coded pair. Each character is one of the nucleotide letters A, C, G or T. The byte input and the character output each use a valid/ready handshake. The block takes the next byte only after the last character of the current frame has been taken, so it works as a simple one-frame-at-a-time transformer.

Top module: `conv_nuc_enc`

## Requirements
- R1: `msg_ready_o` is high only when the block is idle. A byte is captured on a clock edge where `msg_valid_i` and `msg_ready_o` are both high, and `msg_ready_o` is low in the cycle after that edge.
- R2: Encoding takes one clock per message bit. `chr_valid_o` and `code_valid_o` go high exactly 8 clock edges after the edge that accepted the byte.
- R3: Message bits are used MSB first. With current bit b and stored bits s1 (the previous bit) and s2 (the bit before that), the first coded bit is b^s1^s2 and the second is b^s2. The pair for message bit i (i=0 is the MSB) sits at `code_word_o[15-2i : 14-2i]`, with the first coded bit in the higher position.
- R4: Both encoder state bits are zero at the start of every byte, so the codeword depends only on the current byte.
- R5: Each coded pair becomes one ASCII character: 00 gives 8'h41 ('A'), 01 gives 8'h43 ('C'), 10 gives 8'h47 ('G') and 11 gives 8'h54 ('T').
- R6: The eight characters come out in codeword order, starting from `code_word_o[15:14]`. The block moves to the next character on each edge where `chr_valid_o` and `chr_ready_i` are both high.
- R7: While `chr_valid_o` is high and `chr_ready_i` is low, `chr_data_o` and `chr_valid_o` keep their values.
- R8: No byte is accepted while characters are pending. `msg_ready_o` is low while `chr_valid_o` is high, and it goes high in the cycle after the eighth character is taken.
- R9: `code_valid_o` stays high, and `code_word_o` stays unchanged, from the first character until the eighth character is taken.
- R10: After reset the block is idle: `msg_ready_o` is 1, and `chr_valid_o` and `code_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | A message byte is offered |
| msg_data_i | input | 8 | The message byte |
| msg_ready_o | output | 1 | The block can accept a byte |
| code_valid_o | output | 1 | The codeword is complete and valid |
| code_word_o | output | 16 | The 16-bit convolutional codeword |
| chr_valid_o | output | 1 | A nucleotide character is available |
| chr_data_o | output | 8 | ASCII nucleotide character |
| chr_ready_i | input | 1 | The sink takes the character |

## Verification
Two events can fall in the same cycle: the handshake that takes the last character, and a new byte that the source is already offering. The bench sets up this collision by holding `msg_valid_i` high with a second byte for the whole character stream, while also stalling `chr_ready_i`. The result is judged at three points. `msg_ready_o` must stay low until the eighth character has been taken. `msg_ready_o` must then rise in the very next cycle. The following codeword must be the one for the waiting byte, computed from a cleared state.

// File: rtl/conv_nuc_pkg.sv
package conv_nuc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ENC  = 2'd1,
    PH_OUT  = 2'd2
  } phase_t;

  localparam logic [7:0] NUC_A = 8'h41;
  localparam logic [7:0] NUC_C = 8'h43;
  localparam logic [7:0] NUC_G = 8'h47;
  localparam logic [7:0] NUC_T = 8'h54;

  function automatic logic [7:0] pair_to_nuc(input logic [1:0] pair);
    case (pair)
      2'b00:   return NUC_A;
      2'b01:   return NUC_C;
      2'b10:   return NUC_G;
      default: return NUC_T;
    endcase
  endfunction

endpackage

// File: rtl/conv_nuc_core.sv
module conv_nuc_core #(
  parameter int unsigned MSG_W = 8,
  parameter logic [2:0]  GEN_A = 3'b111,
  parameter logic [2:0]  GEN_B = 3'b101,
  localparam int unsigned CODE_W = 2 * MSG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MSG_W-1:0]  data_i,
  input  logic              step_i,
  output logic [CODE_W-1:0] code_o
);

  logic [MSG_W-1:0]  msg_q;
  logic [1:0]        st_q;   // st_q[1]: previous bit, st_q[0]: bit before
  logic [CODE_W-1:0] code_q;
  logic [2:0]        taps;
  logic [1:0]        pair;

  assign taps = {msg_q[MSG_W-1], st_q};
  assign pair = {^(taps & GEN_A), ^(taps & GEN_B)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_q  <= '0;
      st_q   <= '0;
      code_q <= '0;
    end else if (load_i) begin
      msg_q  <= data_i;
      st_q   <= '0;
      code_q <= '0;
    end else if (step_i) begin
      msg_q  <= {msg_q[MSG_W-2:0], 1'b0};
      st_q   <= {msg_q[MSG_W-1], st_q[1]};
      code_q <= {code_q[CODE_W-3:0], pair};
    end
  end

  assign code_o = code_q;

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (st_q == 2'b00));

endmodule

// File: rtl/conv_nuc_ctrl.sv
module conv_nuc_ctrl
  import conv_nuc_pkg::*;
#(
  parameter int unsigned MSG_W = 8,
  localparam int unsigned CNT_W = (MSG_W > 1) ? $clog2(MSG_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msg_valid_i,
  input  logic             chr_ready_i,
  output logic             msg_ready_o,
  output logic             load_o,
  output logic             step_o,
  output logic             stream_o,
  output logic [CNT_W-1:0] idx_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(MSG_W - 1);

  phase_t           ph_q;
  logic [CNT_W-1:0] cnt_q;

  assign msg_ready_o = (ph_q == PH_IDLE);
  assign load_o      = msg_ready_o && msg_valid_i;
  assign step_o      = (ph_q == PH_ENC);
  assign stream_o    = (ph_q == PH_OUT);
  assign idx_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (msg_valid_i) begin
          ph_q  <= PH_ENC;
          cnt_q <= '0;
        end
        PH_ENC: begin
          if (cnt_q == LAST) begin
            ph_q  <= PH_OUT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_OUT: if (chr_ready_i) begin
          if (cnt_q == LAST) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && msg_ready_o) |=> (!msg_ready_o && step_o));

endmodule

// File: rtl/conv_nuc_map.sv
module conv_nuc_map
  import conv_nuc_pkg::*;
#(
  parameter int unsigned MSG_W = 8,
  localparam int unsigned CODE_W = 2 * MSG_W,
  localparam int unsigned CNT_W  = (MSG_W > 1) ? $clog2(MSG_W) : 1
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [CNT_W-1:0]  idx_i,
  output logic [7:0]        chr_o
);

  logic [CODE_W-1:0] shifted;

  // Pair idx_i is moved to the top two bits
  assign shifted = code_i << {idx_i, 1'b0};
  assign chr_o   = pair_to_nuc(shifted[CODE_W-1 -: 2]);

endmodule

// File: rtl/conv_nuc_enc.sv
module conv_nuc_enc #(
  parameter int unsigned MSG_W = 8,
  parameter logic [2:0]  GEN_A = 3'b111,
  parameter logic [2:0]  GEN_B = 3'b101,
  localparam int unsigned CODE_W = 2 * MSG_W,
  localparam int unsigned CNT_W  = (MSG_W > 1) ? $clog2(MSG_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  input  logic [MSG_W-1:0]  msg_data_i,
  output logic              msg_ready_o,
  output logic              code_valid_o,
  output logic [CODE_W-1:0] code_word_o,
  output logic              chr_valid_o,
  output logic [7:0]        chr_data_o,
  input  logic              chr_ready_i
);

  logic             load, step, stream;
  logic [CNT_W-1:0] idx;

  conv_nuc_ctrl #(.MSG_W(MSG_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .msg_valid_i (msg_valid_i),
    .chr_ready_i (chr_ready_i),
    .msg_ready_o (msg_ready_o),
    .load_o      (load),
    .step_o      (step),
    .stream_o    (stream),
    .idx_o       (idx)
  );

  conv_nuc_core #(.MSG_W(MSG_W), .GEN_A(GEN_A), .GEN_B(GEN_B)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (msg_data_i),
    .step_i (step),
    .code_o (code_word_o)
  );

  conv_nuc_map #(.MSG_W(MSG_W)) u_map (
    .code_i (code_word_o),
    .idx_i  (idx),
    .chr_o  (chr_data_o)
  );

  assign chr_valid_o  = stream;
  assign code_valid_o = stream;

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr_valid_o && !chr_ready_i) |=> (chr_valid_o && $stable(chr_data_o)));

  assert_no_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_valid_o |-> !msg_ready_o);

  assert_code_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_valid_o && $past(code_valid_o)) |-> $stable(code_word_o));

  assert_letter_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_valid_o |-> (chr_data_o == 8'h41 || chr_data_o == 8'h43 ||
                     chr_data_o == 8'h47 || chr_data_o == 8'h54));

endmodule

// File: tb/conv_nuc_enc_test.sv
module conv_nuc_enc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [7:0]  msg_data = '0;
  logic        msg_ready;
  logic        code_valid;
  logic [15:0] code_word;
  logic        chr_valid;
  logic [7:0]  chr_data;
  logic        chr_ready = 1'b0;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  conv_nuc_enc uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .msg_valid_i  (msg_valid),
    .msg_data_i   (msg_data),
    .msg_ready_o  (msg_ready),
    .code_valid_o (code_valid),
    .code_word_o  (code_word),
    .chr_valid_o  (chr_valid),
    .chr_data_o   (chr_data),
    .chr_ready_i  (chr_ready)
  );

  // {message byte, expected codeword}, worked out by hand
  localparam int NV = 5;
  localparam logic [23:0] VEC [NV] = '{
    {8'h2D, 16'h0E14},
    {8'h00, 16'h0000},
    {8'hFF, 16'hDAAA},
    {8'h80, 16'hEC00},
    {8'h01, 16'h0003}
  };

  function automatic logic [7:0] ref_letter(input logic [1:0] p);
    case (p)
      2'b00: return 8'h41;
      2'b01: return 8'h43;
      2'b10: return 8'h47;
      default: return 8'h54;
    endcase
  endfunction

  function automatic logic [15:0] ref_encode(input logic [7:0] m);
    logic s1, s2, b;
    logic [15:0] w;
    s1 = 0; s2 = 0; w = '0;
    for (int i = 7; i >= 0; i--) begin
      b = m[i];
      w = {w[13:0], b ^ s1 ^ s2, b ^ s2};
      s2 = s1; s1 = b;
    end
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Sends one byte; optional stall on characters; optional pending byte offered during the stream
  task automatic run_frame(input logic [7:0] b, input logic [15:0] exp, input int stall,
                           input bit pend, input logic [7:0] pb);
    @(negedge clk);
    msg_valid = 1'b1;
    msg_data  = b;
    while (!msg_ready) @(negedge clk);
    @(negedge clk);                       // accepted at the edge just passed
    chk(!msg_ready, "R1 ready low after accept", msg_ready, 0);
    msg_valid = pend;
    msg_data  = pend ? pb : 8'h00;
    repeat (7) @(negedge clk);
    chk(!chr_valid, "R2 no char before 8 cycles", chr_valid, 0);
    @(negedge clk);
    chk(chr_valid && code_valid, "R2 valid after 8 cycles", {chr_valid, code_valid}, 2'b11);
    chk(code_word == exp, "R3 R4 codeword", code_word, exp);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      e = ref_letter(exp[15-2*i -: 2]);
      chr_ready = 1'b0;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(chr_valid && chr_data == e, "R7 hold under stall", chr_data, e);
      end
      chk(chr_data == e, "R5 R6 character", chr_data, e);
      chk(!msg_ready, "R8 no accept while streaming", msg_ready, 0);
      chk(code_valid && code_word == exp, "R9 codeword stable", code_word, exp);
      chr_ready = 1'b1;
      @(negedge clk);
    end
    chr_ready = 1'b0;
    chk(msg_ready && !chr_valid, "R8 ready after last char", {msg_ready, chr_valid}, 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(msg_ready && !chr_valid && !code_valid, "R10 reset state",
        {msg_ready, chr_valid, code_valid}, 3'b100);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++)
      run_frame(VEC[v][23:16], VEC[v][15:0], v % 3, 1'b0, 8'h00);

    // R4: a byte after all-ones must not inherit state
    run_frame(8'hFF, 16'hDAAA, 0, 1'b0, 8'h00);
    run_frame(8'h01, 16'h0003, 0, 1'b0, 8'h00);

    // R8: pending byte held during a stalled stream, taken right after the last char
    run_frame(8'hA5, ref_encode(8'hA5), 2, 1'b1, 8'h3C);
    @(negedge clk);
    chk(!msg_ready, "R8 pending byte taken at once", msg_ready, 0);
    msg_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(chr_valid && code_word == ref_encode(8'h3C), "R8 pending codeword",
        code_word, ref_encode(8'h3C));
    for (int i = 0; i < 8; i++) begin
      chk(chr_data == ref_letter(ref_encode(8'h3C)[15-2*i -: 2]), "R6 pending chars",
          chr_data, ref_letter(ref_encode(8'h3C)[15-2*i -: 2]));
      chr_ready = 1'b1;
      @(negedge clk);
    end
    chr_ready = 1'b0;

    for (int m = 0; m < 6; m++) begin
      logic [7:0] bb;
      bb = 8'(m * 47 + 19);
      run_frame(bb, ref_encode(bb), m % 2, 1'b0, 8'h00);
    end

    // R10: reset in mid stream returns to idle
    @(negedge clk);
    msg_valid = 1'b1; msg_data = 8'h77;
    @(negedge clk);
    msg_valid = 1'b0;
    repeat (9) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(msg_ready && !chr_valid && !code_valid, "R10 reset mid frame",
        {msg_ready, chr_valid, code_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule